// File: doc/BRIEF.md
# Debug Mailbox Register with Dirty Flag

This block gives software running on a CPU a one-byte channel to an external debugger. The CPU writes a byte into a mailbox register, which raises a dirty flag. The debugger polls the flag and reads the byte through its own port. That read clears the flag, so the CPU can tell when the byte has been consumed. When the CPU reads the mailbox, it sees the seven low data bits with the dirty flag in the top bit.

The mailbox shares its CPU address with an ordinary I/O register that lives outside this block. The mailbox takes an access only when two conditions hold: the debug-enable fuse input is high and the debugger has granted access. In every other case the block passes the CPU's read and write strobes on to the ordinary register and returns that register's read data.

Top module: `dbg_mailbox`

## Requirements
- R1: After a synchronous reset, the stored byte is 0x00 and the dirty flag is 0.
- R2: A CPU write routed to the mailbox stores the write byte and sets the dirty flag. Both become visible on the debugger port after that clock edge.
- R3: A CPU read routed to the mailbox returns stored bits 6..0 in bits 6..0 and the dirty flag in bit 7.
- R4: A debugger read strobe clears the dirty flag at the next edge. The debugger data output always shows all 8 stored bits.
- R5: When a routed CPU write and a debugger read fall in the same cycle, the dirty flag ends up 1 and the new byte is stored.
- R6: The mailbox takes a CPU access only when the address select, the fuse input and the grant input are all high.
- R7: When the select is high but the fuse or the grant is low, CPU strobes go out on the I/O strobe outputs, CPU read data comes from the I/O read-data input, and the stored byte and dirty flag stay unchanged.
- R8: A CPU read of the mailbox changes neither the stored byte nor the dirty flag.
- R9: When the select is low, both I/O strobes stay low and the CPU read data is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 1 | CPU address matches the shared location |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | CPU read byte (mailbox view or I/O register) |
| fuse_dbg_en | input | 1 | Debug-enable fuse state |
| dbg_grant | input | 1 | Debugger grants CPU access to the mailbox |
| io_rd | output | 1 | Read strobe steered to the ordinary I/O register |
| io_wr | output | 1 | Write strobe steered to the ordinary I/O register |
| io_rdata | input | 8 | Read data from the ordinary I/O register |
| dbg_rd | input | 1 | Debugger read strobe (clears the dirty flag) |
| dbg_data | output | 8 | Full stored byte for the debugger |
| dbg_dirty | output | 1 | Dirty flag for the debugger |

## Verification
The embedded assertions run on every cycle and cover four things:
- A routed write sets the flag and stores the byte.
- A lone debugger read clears the flag.
- Mailbox and I/O strobes are never both active.
- With no write and no debugger read, the state holds.

Two points appear only in the bench's scenarios, because they depend on the input sequence rather than on any single cycle:
- A fuse or grant toggling mid-sequence redirects accesses without disturbing the mailbox.
- The flag stays set through a write that collides with a debugger read and falls only on a later debugger read.

// File: rtl/dbg_mbox_pkg.sv
package dbg_mbox_pkg;

    localparam int unsigned MBOX_DATA_W = 8;

    typedef struct packed {
        logic mb_rd;
        logic mb_wr;
        logic io_rd;
        logic io_wr;
    } mbox_route_t;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_MBOX = 2'd1,
        SRC_IO   = 2'd2
    } rd_src_e;

    function automatic mbox_route_t route_access(
        input logic sel,
        input logic rd,
        input logic wr,
        input logic fuse,
        input logic grant
    );
        mbox_route_t r;
        logic to_mbox;
        to_mbox = fuse & grant;
        r.mb_rd = sel & rd & to_mbox;
        r.mb_wr = sel & wr & to_mbox;
        r.io_rd = sel & rd & ~to_mbox;
        r.io_wr = sel & wr & ~to_mbox;
        return r;
    endfunction

    function automatic rd_src_e pick_source(input mbox_route_t r);
        if (r.mb_rd)      return SRC_MBOX;
        else if (r.io_rd) return SRC_IO;
        else              return SRC_NONE;
    endfunction

endpackage

// File: rtl/mbox_steer.sv
module mbox_steer
    import dbg_mbox_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sel,
    input  logic        rd,
    input  logic        wr,
    input  logic        fuse,
    input  logic        grant,
    output mbox_route_t route,
    output rd_src_e     src
);

    always_comb begin
        route = route_access(sel, rd, wr, fuse, grant);
        src   = pick_source(route);
    end

    // R6
    mbox_io_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(route.mb_wr && route.io_wr));

    // R7
    mbox_io_rd_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(route.mb_rd && route.io_rd));

endmodule

// File: rtl/mbox_store.sv
module mbox_store #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              dbg_rd,
    output logic [DATA_W-1:0] data,
    output logic              dirty
);

    logic [DATA_W-1:0] data_q;
    logic              dirty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            dirty_q <= 1'b0;
        end else begin
            if (wr_en) begin
                data_q <= wdata;
            end
            if (wr_en) begin
                dirty_q <= 1'b1;
            end else if (dbg_rd) begin
                dirty_q <= 1'b0;
            end
        end
    end

    assign data  = data_q;
    assign dirty = dirty_q;

    // R2
    wr_sets_dirty_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (dirty && data == $past(wdata)));

    // R4
    dbg_rd_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (dbg_rd && !wr_en) |=> !dirty);

    // R8
    idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !dbg_rd) |=> ($stable(data) && $stable(dirty)));

endmodule

// File: rtl/mbox_rdview.sv
module mbox_rdview
    import dbg_mbox_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  rd_src_e           src,
    input  logic [DATA_W-2:0] store_low,
    input  logic              dirty,
    input  logic [DATA_W-1:0] io_rdata,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        unique case (src)
            SRC_MBOX: rdata = {dirty, store_low};
            SRC_IO:   rdata = io_rdata;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
    import dbg_mbox_pkg::*;
#(
    parameter int unsigned DATA_W = MBOX_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_sel,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              fuse_dbg_en,
    input  logic              dbg_grant,
    output logic              io_rd,
    output logic              io_wr,
    input  logic [DATA_W-1:0] io_rdata,
    input  logic              dbg_rd,
    output logic [DATA_W-1:0] dbg_data,
    output logic              dbg_dirty
);

    localparam int unsigned LOW_W = DATA_W - 1;

    mbox_route_t       route;
    rd_src_e           src;
    logic [DATA_W-1:0] store_data;
    logic              store_dirty;

    mbox_steer u_steer (
        .clk   (clk),
        .rst   (rst),
        .sel   (cpu_sel),
        .rd    (cpu_rd),
        .wr    (cpu_wr),
        .fuse  (fuse_dbg_en),
        .grant (dbg_grant),
        .route (route),
        .src   (src)
    );

    mbox_store #(.DATA_W(DATA_W)) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (route.mb_wr),
        .wdata  (cpu_wdata),
        .dbg_rd (dbg_rd),
        .data   (store_data),
        .dirty  (store_dirty)
    );

    mbox_rdview #(.DATA_W(DATA_W)) u_rdview (
        .src       (src),
        .store_low (store_data[LOW_W-1:0]),
        .dirty     (store_dirty),
        .io_rdata  (io_rdata),
        .rdata     (cpu_rdata)
    );

    assign io_rd     = route.io_rd;
    assign io_wr     = route.io_wr;
    assign dbg_data  = store_data;
    assign dbg_dirty = store_dirty;

    // R3
    cpu_view_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_sel && cpu_rd && fuse_dbg_en && dbg_grant) |->
        (cpu_rdata == {dbg_dirty, dbg_data[LOW_W-1:0]}));

    // R9
    unselected_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cpu_sel |-> (!io_rd && !io_wr && cpu_rdata == '0));

endmodule

// File: tb/dbg_mailbox_bench.sv
`timescale 1ns/1ps
module dbg_mailbox_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       cpu_sel, cpu_rd, cpu_wr;
    logic [7:0] cpu_wdata;
    logic [7:0] cpu_rdata;
    logic       fuse_dbg_en, dbg_grant;
    logic       io_rd, io_wr;
    logic [7:0] io_rdata;
    logic       dbg_rd;
    logic [7:0] dbg_data;
    logic       dbg_dirty;

    int checks = 0;
    int errors = 0;
    int m_data = 0;
    int m_dirty = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dbg_mailbox u_dbg_mailbox (
        .clk(clk), .rst(rst),
        .cpu_sel(cpu_sel), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .fuse_dbg_en(fuse_dbg_en), .dbg_grant(dbg_grant),
        .io_rd(io_rd), .io_wr(io_wr), .io_rdata(io_rdata),
        .dbg_rd(dbg_rd), .dbg_data(dbg_data), .dbg_dirty(dbg_dirty)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(input string req);
        int hit, exp_rd, exp_iord, exp_iowr;
        hit = cpu_sel && fuse_dbg_en && dbg_grant;
        if (cpu_sel && cpu_rd)
            exp_rd = hit ? ((m_dirty << 7) | (m_data % 128)) : int'(io_rdata);
        else
            exp_rd = 0;
        exp_iord = (cpu_sel && cpu_rd && !hit) ? 1 : 0;
        exp_iowr = (cpu_sel && cpu_wr && !hit) ? 1 : 0;
        check(req, "cpu_rdata", int'(cpu_rdata), exp_rd);
        check(req, "io_rd", int'(io_rd), exp_iord);
        check(req, "io_wr", int'(io_wr), exp_iowr);
        check(req, "dbg_data", int'(dbg_data), m_data);
        check(req, "dbg_dirty", int'(dbg_dirty), m_dirty);
    endtask

    // One cycle: drive at the falling edge, compare, then update the model at the rising edge.
    task automatic step(input string req, input bit sel, input bit rd, input bit wr,
                        input int wd, input bit fuse, input bit grant,
                        input int iod, input bit drd);
        bit hit;
        cpu_sel = sel; cpu_rd = rd; cpu_wr = wr; cpu_wdata = wd[7:0];
        fuse_dbg_en = fuse; dbg_grant = grant; io_rdata = iod[7:0]; dbg_rd = drd;
        #2;
        compare_all(req);
        @(posedge clk);
        hit = sel && fuse && grant;
        if (hit && wr) begin
            m_data = wd % 256;
            m_dirty = 1;
        end else if (drd) begin
            m_dirty = 0;
        end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        cpu_sel = 0; cpu_rd = 0; cpu_wr = 0; cpu_wdata = 0;
        fuse_dbg_en = 0; dbg_grant = 0; io_rdata = 0; dbg_rd = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        step("R1", 0, 0, 0, 0, 0, 0, 8'h00, 0);
        // R9 unselected strobes are ignored
        step("R9", 0, 1, 1, 8'h5A, 1, 1, 8'h77, 0);
        // R2 routed write sets the flag
        step("R2", 1, 0, 1, 8'hC3, 1, 1, 8'h00, 0);
        step("R2", 0, 0, 0, 0, 1, 1, 8'h00, 0);
        // R3 CPU view with the flag in bit 7; R8 the read has no side effect
        step("R3", 1, 1, 0, 0, 1, 1, 8'h11, 0);
        step("R8", 1, 1, 0, 0, 1, 1, 8'h11, 0);
        // R4 debugger read clears the flag
        step("R4", 0, 0, 0, 0, 1, 1, 8'h00, 1);
        step("R4", 1, 1, 0, 0, 1, 1, 8'h00, 0);
        // R5 write colliding with a debugger read keeps the flag set
        step("R5", 1, 0, 1, 8'h3C, 1, 1, 8'h00, 1);
        step("R5", 1, 1, 0, 0, 1, 1, 8'h00, 0);
        step("R5", 0, 0, 0, 0, 1, 1, 8'h00, 1);
        // R6 R7 fuse low: accesses go to the I/O register
        step("R7", 1, 0, 1, 8'hFF, 0, 1, 8'hA5, 0);
        step("R7", 1, 1, 0, 0, 0, 1, 8'hA5, 0);
        // R6 R7 grant low
        step("R6", 1, 0, 1, 8'h81, 1, 0, 8'h96, 0);
        step("R6", 1, 1, 0, 0, 1, 0, 8'h96, 0);
        step("R6", 0, 0, 0, 0, 1, 1, 8'h00, 0);
        // R2 R3 high-bit byte: bit 7 of data hidden from the CPU view
        step("R2", 1, 0, 1, 8'h80, 1, 1, 8'h00, 0);
        step("R3", 1, 1, 0, 0, 1, 1, 8'h00, 0);
        step("R4", 1, 1, 0, 0, 1, 1, 8'h00, 1);
        step("R3", 1, 1, 0, 0, 1, 1, 8'h00, 0);
        // R1 reset mid-run
        rst = 1'b1;
        @(posedge clk);
        m_data = 0; m_dirty = 0;
        @(negedge clk);
        rst = 1'b0;
        step("R1", 0, 0, 0, 0, 0, 0, 8'h00, 0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule